// File: doc/BRIEF.md
# Tri-State PWM Gate Control Sequencer

This block turns a three-level PWM command into the two gate enables of a synchronous buck stage: one for the high-side switch and one for the low-side switch. The command arrives already resolved into low, high and mid (tri-state) levels. A high command selects the high-side switch, a low command selects the low-side switch, and the mid level turns both off so the inductor current flows through the body diode. The mid level serves body braking and diode emulation.

Before either gate turns on, the block makes sure the other gate has been off for a programmable number of clock cycles. It holds both gates off while the enable input is low, while the power-on wait after enable runs, during undervoltage and during an over-temperature shutdown request. While enable is low it also flags deep sleep, which tells the current-report output to short to its reference. An over-current trip during a high-side pulse ends that pulse early and hands conduction to the low-side switch. The low-side switch keeps conducting until the command leaves high and comes back.

Top module: `pwm_gate_seq`

## Requirements
- R1: The high-side gate rises only when the low-side gate has been low for at least DEAD_CYC cycles. Code 2'b01 on `pwm_lvl` means high. With the command held high after a low-side period, `hs_on` rises on the (DEAD_CYC+1)th clock edge after the change. From a long idle it rises on the first edge.
- R2: The low-side gate follows the same rule for code 2'b00 (low). With the command held low after a high-side period, `ls_on` rises on the (DEAD_CYC+1)th edge after the change.
- R3: Code 2'b10 (mid), and also the unused code 2'b11, turns both gates off at the next clock edge and keeps them off.
- R4: While `en` is low, both gate outputs are low in the same cycle, `sleep` is high, and `ready` is low after the next edge.
- R5: After `en` is sampled high, `ready` rises on the WAKE_CYC-th edge. Until then the PWM command is ignored and both gates stay low.
- R6: While `uv_fault` is high, both gates are low in the same cycle. Switching resumes, subject to R1 and R2, once it clears.
- R7: If `oc_trip` is high while the high-side gate is on, the high-side gate falls at the next edge. The low-side gate then turns on after the dead time and stays on while the command stays high. Normal high-side pulses return after the command goes low and high again. `oc_trip` has no effect while the high-side gate is off.
- R8: While `ot_shdn` is high, both gates are low in the same cycle. Switching resumes once it is released.
- R9: `hs_on` and `ls_on` are never high together.
- R10: During reset, both gates are low and `ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwm_lvl | input | 2 | Resolved PWM level: 00 low, 01 high, 10 or 11 mid |
| en | input | 1 | Stage enable; low means deep sleep |
| uv_fault | input | 1 | Supply undervoltage indication |
| ot_shdn | input | 1 | Over-temperature shutdown request |
| oc_trip | input | 1 | Cycle-by-cycle over-current comparator |
| hs_on | output | 1 | High-side gate enable |
| ls_on | output | 1 | Low-side gate enable |
| ready | output | 1 | Power-on wait complete, commands accepted |
| sleep | output | 1 | Deep sleep; current report shorted to reference |

## Verification
The hardest state to reach is the truncated pulse. The stimulus first builds a full high-side pulse, then raises the over-current input for exactly one cycle. It keeps the command high past the dead time, so the low-side hold can be seen. The command then goes low and high again to show that a normal high-side pulse comes back. The dead-time boundary is checked one cycle before and on the edge where each gate may rise. Lockout release is checked after the off counter has saturated, so the resumed gate must rise on the first edge.

// File: rtl/pgs_pkg.sv
// Shared types for the PWM gate sequencer.
// Assumes the PWM level arrives already resolved into two bits.
package pgs_pkg;
    typedef enum logic [1:0] {
        PWM_LO  = 2'b00,
        PWM_HI  = 2'b01,
        PWM_MID = 2'b10
    } pwm_lvl_e;
endpackage

// File: rtl/pgs_wake.sv
// Enable and deep-sleep timing. Counts WAKE_CYC sampled-high cycles of the
// enable input before declaring the stage ready; a low enable clears it.
// Assumes WAKE_CYC >= 1.
module pgs_wake #(
    parameter int WAKE_CYC = 625
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic ready,
    output logic sleep
);
    localparam int CW = $clog2(WAKE_CYC + 1);

    logic [CW-1:0] cnt;

    // Power-on wait counter and ready flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            ready <= 1'b0;
        end else if (!en) begin
            cnt   <= '0;
            ready <= 1'b0;
        end else if (!ready) begin
            if (cnt == CW'(WAKE_CYC - 1)) ready <= 1'b1;
            else                          cnt   <= cnt + CW'(1);
        end
    end

    // Deep sleep follows the enable level directly.
    always_comb sleep = !en;

    a_r5_ready_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(en));
    a_r4_sleep_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !ready);
endmodule

// File: rtl/pgs_deadtime.sv
// Off-time counter. Counts consecutive cycles in which both gate registers
// are off (the current one included) and saturates at DEAD_CYC. Starts
// saturated so the first turn-on after reset is not delayed.
// Assumes DEAD_CYC >= 1.
module pgs_deadtime #(
    parameter int DEAD_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic off_next,
    output logic dead_ok
);
    localparam int CW = $clog2(DEAD_CYC + 1);

    logic [CW-1:0] cnt;

    // Count off cycles; clear when a gate turns on.
    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt <= CW'(DEAD_CYC);
        else if (!off_next)           cnt <= '0;
        else if (cnt != CW'(DEAD_CYC)) cnt <= cnt + CW'(1);
    end

    // Dead time met once the count has saturated.
    always_comb dead_ok = (cnt == CW'(DEAD_CYC));
endmodule

// File: rtl/pgs_gate_fsm.sv
// Gate selection. Keeps one register per gate and decides the next gate
// state from the command, the lockout, the over-current input and the
// dead-time flag. A tripped high-side pulse sets a hold that selects the
// low side until the command leaves high.
// Assumes block already merges every lockout source.
module pgs_gate_fsm
    import pgs_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  pwm_lvl_e pwm,
    input  logic     block,
    input  logic     oc_trip,
    input  logic     dead_ok,
    output logic     hs_q,
    output logic     ls_q,
    output logic     off_next
);
    logic trunc_q, trunc_n;
    logic want_hs, want_ls;
    logic hs_n, ls_n;

    // Requested gate after applying the truncation hold.
    always_comb begin
        want_hs = (pwm == PWM_HI) && !trunc_q;
        want_ls = (pwm == PWM_LO) || ((pwm == PWM_HI) && trunc_q);
    end

    // Next gate state: turn off at once, turn on only after the dead time.
    always_comb begin
        hs_n = 1'b0;
        ls_n = 1'b0;
        if (block) begin
            hs_n = 1'b0;
            ls_n = 1'b0;
        end else if (hs_q) begin
            hs_n = want_hs && !oc_trip;
        end else if (ls_q) begin
            ls_n = want_ls;
        end else begin
            hs_n = want_hs && dead_ok;
            ls_n = want_ls && dead_ok;
        end
        off_next = !hs_n && !ls_n;
        trunc_n  = (pwm == PWM_HI) && (trunc_q || (hs_q && oc_trip));
    end

    // Gate and hold registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_q    <= 1'b0;
            ls_q    <= 1'b0;
            trunc_q <= 1'b0;
        end else begin
            hs_q    <= hs_n;
            ls_q    <= ls_n;
            trunc_q <= trunc_n;
        end
    end

    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_q && ls_q));
    a_r1_hs_after_dead: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_q) |-> $past(dead_ok && !ls_q));
    a_r2_ls_after_dead: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_q) |-> $past(dead_ok && !hs_q));
    a_r7_cut_short: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_q && oc_trip) |=> !hs_q);
    a_r3_mid_off: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm != PWM_HI && pwm != PWM_LO) |=> (!hs_q && !ls_q));
endmodule

// File: rtl/pwm_gate_seq.sv
// Top of the tri-state PWM gate sequencer. Merges the lockouts, gates the
// registered gate states so that any lockout drops the outputs in the same
// cycle, and wires the wake timer, dead-time counter and gate selector.
// Assumes all inputs are synchronous to clk.
module pwm_gate_seq
    import pgs_pkg::*;
#(
    parameter int DEAD_CYC = 3,
    parameter int WAKE_CYC = 625
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] pwm_lvl,
    input  logic       en,
    input  logic       uv_fault,
    input  logic       ot_shdn,
    input  logic       oc_trip,
    output logic       hs_on,
    output logic       ls_on,
    output logic       ready,
    output logic       sleep
);
    logic     block, dead_ok, off_next, hs_q, ls_q;
    pwm_lvl_e pwm;

    // Decode the level and merge all lockout sources.
    always_comb begin
        pwm   = pwm_lvl_e'(pwm_lvl);
        block = !en || !ready || uv_fault || ot_shdn;
    end

    pgs_wake #(.WAKE_CYC(WAKE_CYC)) u_wake (
        .clk(clk), .rst_n(rst_n), .en(en), .ready(ready), .sleep(sleep)
    );

    pgs_deadtime #(.DEAD_CYC(DEAD_CYC)) u_dead (
        .clk(clk), .rst_n(rst_n), .off_next(off_next), .dead_ok(dead_ok)
    );

    pgs_gate_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .pwm(pwm), .block(block),
        .oc_trip(oc_trip), .dead_ok(dead_ok),
        .hs_q(hs_q), .ls_q(ls_q), .off_next(off_next)
    );

    // Outputs drop in the same cycle as any lockout.
    always_comb begin
        hs_on = hs_q && !block;
        ls_on = ls_q && !block;
    end

    a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_on && ls_on));
    a_r4_sleep_off: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> (!hs_on && !ls_on));
    a_r6_uv_off: assert property (@(posedge clk) disable iff (!rst_n)
        uv_fault |-> (!hs_on && !ls_on));
    a_r8_ot_off: assert property (@(posedge clk) disable iff (!rst_n)
        ot_shdn |-> (!hs_on && !ls_on));
endmodule

// File: tb/pwm_gate_seq_test.sv
module pwm_gate_seq_test;
    localparam int DEAD = 3;
    localparam int WAKE = 625;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] pwm_lvl = 2'b10;
    logic       en = 1'b0, uv_fault = 1'b0, ot_shdn = 1'b0, oc_trip = 1'b0;
    logic       hs_on, ls_on, ready, sleep;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pwm_gate_seq #(.DEAD_CYC(DEAD), .WAKE_CYC(WAKE)) uut (
        .clk(clk), .rst_n(rst_n), .pwm_lvl(pwm_lvl), .en(en),
        .uv_fault(uv_fault), .ot_shdn(ot_shdn), .oc_trip(oc_trip),
        .hs_on(hs_on), .ls_on(ls_on), .ready(ready), .sleep(sleep)
    );

    typedef struct packed {
        logic [1:0] pwm;
        logic       uv;
        logic       ot;
        logic       oc;
        logic [2:0] wt;
        logic       hs;
        logic       ls;
        logic [3:0] req;
    } vec_t;

    // Stimulus rows: level, uv, ot, oc, wait cycles (0 = same cycle), expected hs/ls, requirement.
    localparam int NV = 17;
    localparam vec_t VECS [0:NV-1] = '{
        '{2'b01, 1'b0, 1'b0, 1'b0, 3'd1, 1'b1, 1'b0, 4'd1},  // R1 from idle
        '{2'b00, 1'b0, 1'b0, 1'b0, 3'd3, 1'b0, 1'b0, 4'd2},  // R2 dead time running
        '{2'b00, 1'b0, 1'b0, 1'b0, 3'd1, 1'b0, 1'b1, 4'd2},  // R2 low side on
        '{2'b01, 1'b0, 1'b0, 1'b0, 3'd3, 1'b0, 1'b0, 4'd1},  // R1 dead time running
        '{2'b01, 1'b0, 1'b0, 1'b0, 3'd1, 1'b1, 1'b0, 4'd1},  // R1 high side on
        '{2'b10, 1'b0, 1'b0, 1'b0, 3'd1, 1'b0, 1'b0, 4'd3},  // R3 mid level
        '{2'b11, 1'b0, 1'b0, 1'b0, 3'd5, 1'b0, 1'b0, 4'd3},  // R3 unused code
        '{2'b00, 1'b0, 1'b0, 1'b0, 3'd1, 1'b0, 1'b1, 4'd2},  // R2 after long idle
        '{2'b00, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 4'd6},  // R6 same cycle
        '{2'b00, 1'b1, 1'b0, 1'b0, 3'd4, 1'b0, 1'b0, 4'd6},  // R6 held
        '{2'b00, 1'b0, 1'b0, 1'b0, 3'd1, 1'b0, 1'b1, 4'd6},  // R6 resume
        '{2'b01, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 4'd8},  // R8 same cycle
        '{2'b01, 1'b0, 1'b1, 1'b0, 3'd3, 1'b0, 1'b0, 4'd8},  // R8 held
        '{2'b01, 1'b0, 1'b0, 1'b0, 3'd1, 1'b1, 1'b0, 4'd8},  // R8 resume
        '{2'b10, 1'b0, 1'b0, 1'b0, 3'd1, 1'b0, 1'b0, 4'd3},  // R3 from high side
        '{2'b00, 1'b0, 1'b0, 1'b0, 3'd4, 1'b0, 1'b1, 4'd2},  // R2
        '{2'b00, 1'b0, 1'b0, 1'b1, 3'd2, 1'b0, 1'b1, 4'd7}   // R7 trip ignored with high side off
    };

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R10 reset state
        tick(3);
        chk("R10 hs in reset", hs_on, 1'b0);
        chk("R10 ls in reset", ls_on, 1'b0);
        chk("R10 ready in reset", ready, 1'b0);
        chk("R4 sleep with en low", sleep, 1'b1);

        // R5 power-on wait with a high command pending
        pwm_lvl = 2'b01; en = 1'b1; rst_n = 1'b1;
        tick(WAKE - 1);
        chk("R5 ready before wait", ready, 1'b0);
        chk("R5 hs ignored during wait", hs_on, 1'b0);
        tick(1);
        chk("R5 ready after wait", ready, 1'b1);
        tick(1);
        chk("R5 hs after ready", hs_on, 1'b1);
        pwm_lvl = 2'b10;
        tick(6);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            pwm_lvl = VECS[i].pwm; uv_fault = VECS[i].uv;
            ot_shdn = VECS[i].ot;  oc_trip  = VECS[i].oc;
            if (VECS[i].wt == 3'd0) #1;
            else tick(int'(VECS[i].wt));
            chk($sformatf("R%0d vec%0d hs", VECS[i].req, i), hs_on, VECS[i].hs);
            chk($sformatf("R%0d vec%0d ls", VECS[i].req, i), ls_on, VECS[i].ls);
            chk($sformatf("R9 vec%0d overlap", i), hs_on && ls_on, 1'b0);
        end
        oc_trip = 1'b0;

        // R7 truncation of a high-side pulse
        pwm_lvl = 2'b01;
        tick(4);
        chk("R7 hs before trip", hs_on, 1'b1);
        oc_trip = 1'b1;
        tick(1);
        oc_trip = 1'b0;
        chk("R7 hs cut at next edge", hs_on, 1'b0);
        tick(2);
        chk("R7 ls waits for dead time", ls_on, 1'b0);
        tick(1);
        chk("R7 ls after dead time", ls_on, 1'b1);
        tick(5);
        chk("R7 ls held while command high", ls_on, 1'b1);
        chk("R7 hs held off while command high", hs_on, 1'b0);
        pwm_lvl = 2'b00;
        tick(1);
        chk("R7 ls on command low", ls_on, 1'b1);
        pwm_lvl = 2'b01;
        tick(4);
        chk("R7 normal pulse after new edge", hs_on, 1'b1);

        // R4 enable drop and R5 re-wake
        en = 1'b0;
        #1;
        chk("R4 hs off same cycle", hs_on, 1'b0);
        chk("R4 ls off same cycle", ls_on, 1'b0);
        chk("R4 sleep high", sleep, 1'b1);
        tick(1);
        chk("R4 ready cleared", ready, 1'b0);
        en = 1'b1;
        tick(WAKE - 1);
        chk("R5 ready low before rewake", ready, 1'b0);
        chk("R5 hs off before rewake", hs_on, 1'b0);
        tick(1);
        chk("R5 ready after rewake", ready, 1'b1);
        chk("R4 sleep low when enabled", sleep, 1'b0);
        tick(1);
        chk("R5 hs after rewake", hs_on, 1'b1);

        finish_run();
    end
endmodule